// File: doc/BRIEF.md
# Mode-Switched Event Counter with Serial Readout

This block counts events on a fast strobe and lets a slow host microcontroller read the total one bit at a time. A single mode pin chooses between two behaviours. While counting, every rising edge of the event strobe adds one to a binary total, and a clear pin sets that total back to zero. While reading, the total is frozen: the strobe and the clear pin have no effect. The captured value leaves the block on one serial pin, one bit for each rising edge of a shift clock driven by the host.

The mode, clear and shift-clock pins come from the host and are asynchronous to the core clock. Each one passes through a synchroniser before the edge logic sees it. The event strobe is captured by a single register and edge-detected in the core clock domain. The counter width is a whole number of bytes. A sticky wrap flag is set when the total passes from all ones to zero. That flag is the first bit sent, so the host can tell a wrapped total from a small one.

The serial output has no valid/ready handshake. The host's shift-clock edges are the only thing that sets the pace, and there is no back-pressure. The block never stalls, and each host edge takes exactly one bit. A host that pauses simply leaves the current bit on the pin for as long as it pauses.

Top module: `msc_serial_counter`

## Requirements
- R1: In count mode, each rising edge of `evt_i` increments the count by exactly one. `evt_i` must hold each level for at least one core clock, so it may toggle at up to half the core clock rate: 50 MHz events with a 100 MHz clock.
- R2: In count mode, a high `zero_i` clears both the count and the wrap flag. The clear wins over an event edge that arrives in the same cycle.
- R3: The count wraps from all ones to zero, and on that wrap the sticky wrap flag is set. The flag stays set until a count-mode clear or a reset.
- R4: A rising edge of `read_mode_i` loads the `WIDTH+1`-bit word {wrap flag, count} into the output shifter. The wrap flag appears on `ser_o` no later than 3 core clocks after the mode pin rises, before any shift pulse.
- R5: In read mode, each rising edge of `shift_clk_i` advances the shifter by one bit, MSB first. The order on `ser_o` is the wrap flag, then count bit `WIDTH-1` down to bit 0. The new bit is present within 3 core clocks of the shift-clock edge.
- R6: Once all `WIDTH+1` bits have been shifted out, `ser_o` stays 0. Further shift pulses change nothing until read mode is entered again.
- R7: In read mode, `evt_i` and `zero_i` are ignored. The count and the wrap flag keep their values, and the next readout shows this.
- R8: Leaving read mode and entering it again, even partway through a readout, restarts the readout from the wrap flag and MSB of the current count.
- R9: A low `rst_ni` asynchronously clears the count, the wrap flag and the shifter, and drives `ser_o` to 0.
- R10: The counter width is `8*BYTES` bits. `BYTES` defaults to 3, which gives a 24-bit count and a 25-bit readout word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Event strobe; rising edges are counted |
| zero_i | input | 1 | Host clear request, level active high, acts in count mode only |
| read_mode_i | input | 1 | Host mode select: 0 = count, 1 = read |
| shift_clk_i | input | 1 | Host shift clock; rising edges advance the readout |
| ser_o | output | 1 | Serial readout bit |

## Verification
An event edge reaches the count 2 core clocks after `evt_i` rises: one capture register, then the counter register. Host pins pass through a 2-stage synchroniser and then an edge register. As a result, the loaded MSB and each shifted bit appear on `ser_o` 3 core clocks after the mode or shift-clock edge. A clear takes effect 3 clocks after `zero_i` rises. The bench holds every host level for 4 core clocks and reads `ser_o` on falling clock edges only after that wait. The count is checked only through full serial readouts. A second instance with `BYTES=1` makes the wrap and the sticky flag reachable within the run.

// File: rtl/msc_pkg.sv
package msc_pkg;
  // Indices of the host-driven pins inside the synchroniser vector.
  localparam int unsigned HOST_W   = 3;
  localparam int unsigned HS_MODE  = 0;
  localparam int unsigned HS_CLR   = 1;
  localparam int unsigned HS_SHIFT = 2;
  // Core-side stage counts.
  localparam int unsigned HOST_SYNC_STAGES = 2;
  localparam int unsigned EVT_CAPTURE_STAGES = 1;
endpackage

// File: rtl/msc_sync.sv
module msc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[0] <= '0;
          else         stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/msc_edge.sv
module msc_edge #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_chk
      // R1 / R5: one level change yields a single-cycle pulse
      a_r1_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o[b] |=> !rise_o[b]);
    end
  endgenerate
endmodule

// File: rtl/msc_count_core.sv
module msc_count_core #(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  input  logic             hold_i,
  output logic [WIDTH-1:0] count_o,
  output logic             wrap_o
);
  logic [WIDTH-1:0] count_q;
  logic             wrap_q;
  logic             at_top;
  logic             do_clr;
  logic             do_inc;

  assign at_top = &count_q;
  assign do_clr = clr_i && !hold_i;
  assign do_inc = inc_i && !hold_i && !do_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      wrap_q  <= 1'b0;
    end else if (do_clr) begin
      count_q <= '0;
      wrap_q  <= 1'b0;
    end else if (do_inc) begin
      count_q <= count_q + 1'b1;
      if (at_top) wrap_q <= 1'b1;
    end
  end

  assign count_o = count_q;
  assign wrap_o  = wrap_q;

  // R1: a non-wrapping event adds exactly one
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !hold_i && !(&count_q)) |=> (count_q == $past(count_q) + 1'b1));
  // R2: clear in count mode zeroes count and flag, even against an event
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hold_i) |=> (count_q == '0 && !wrap_q));
  // R3: wrap from all ones sets the flag
  a_r3_wrap_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && !hold_i && (&count_q)) |=> (wrap_q && count_q == '0));
  // R3: flag is sticky until a clear
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_q && !(clr_i && !hold_i)) |=> wrap_q);
  // R7: read mode freezes the state
  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ($stable(count_q) && $stable(wrap_q)));
endmodule

// File: rtl/msc_shift_out.sv
module msc_shift_out #(
  parameter int unsigned NBITS = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [NBITS-1:0] word_i,
  input  logic             shift_i,
  output logic             ser_o
);
  localparam int unsigned CW = $clog2(NBITS + 1);
  localparam logic [CW-1:0] FULL = CW'(NBITS);

  logic [NBITS-1:0] sh_q;
  logic [CW-1:0]    left_q;
  logic             busy;

  assign busy = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= word_i;
      left_q <= FULL;
    end else if (shift_i && busy) begin
      sh_q   <= {sh_q[NBITS-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign ser_o = busy ? sh_q[NBITS-1] : 1'b0;

  // R4: a load presents the word MSB at once
  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (left_q == FULL && ser_o == $past(word_i[NBITS-1])));
  // R5: each accepted shift consumes exactly one bit
  a_r5_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i && busy) |=> (left_q == $past(left_q) - 1'b1));
  // R6: once drained, further shifts change nothing and output stays low
  a_r6_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !load_i) |=> (!busy && !ser_o));
endmodule

// File: rtl/msc_serial_counter.sv
module msc_serial_counter #(
  parameter int unsigned BYTES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic zero_i,
  input  logic read_mode_i,
  input  logic shift_clk_i,
  output logic ser_o
);
  import msc_pkg::*;

  localparam int unsigned WIDTH = 8 * BYTES;
  localparam int unsigned NBITS = WIDTH + 1;

  logic [HOST_W-1:0] host_raw;
  logic [HOST_W-1:0] host_s;
  logic [1:0]        host_lvl;
  logic [1:0]        host_rise;
  logic              evt_s;
  logic              evt_rise;
  logic [WIDTH-1:0]  count;
  logic              wrap;
  logic              in_read;
  logic              load;
  logic              shift;

  assign host_raw[HS_MODE]  = read_mode_i;
  assign host_raw[HS_CLR]   = zero_i;
  assign host_raw[HS_SHIFT] = shift_clk_i;

  msc_sync #(.W(HOST_W), .STAGES(HOST_SYNC_STAGES)) u_host_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(host_raw), .q_o(host_s)
  );

  msc_sync #(.W(1), .STAGES(EVT_CAPTURE_STAGES)) u_evt_cap (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(evt_i), .q_o(evt_s)
  );

  msc_edge #(.W(1)) u_evt_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(evt_s), .rise_o(evt_rise)
  );

  assign host_lvl = {host_s[HS_SHIFT], host_s[HS_MODE]};

  msc_edge #(.W(2)) u_host_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(host_lvl), .rise_o(host_rise)
  );

  assign in_read = host_s[HS_MODE];
  assign load    = host_rise[0];
  assign shift   = host_rise[1] && in_read;

  msc_count_core #(.WIDTH(WIDTH)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (evt_rise),
    .clr_i  (host_s[HS_CLR]),
    .hold_i (in_read),
    .count_o(count),
    .wrap_o (wrap)
  );

  msc_shift_out #(.NBITS(NBITS)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .word_i ({wrap, count}),
    .shift_i(shift),
    .ser_o  (ser_o)
  );

  // R10: width is a whole number of bytes
  initial begin
    a_r10_width: assert (WIDTH % 8 == 0 && BYTES >= 1);
  end

  // R9: output low while reset is held (checked on the clock)
  a_r9_reset_low: assert property (@(posedge clk_i) !rst_ni |-> !ser_o);
endmodule

// File: tb/msc_serial_counter_tb.sv
module msc_serial_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;
  localparam int WB = 25;
  localparam int WS = 9;
  localparam int NVEC = 9;
  localparam int unsigned VEC_N [NVEC] = '{0, 1, 5, 37, 200, 255, 256, 300, 513};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt = 1'b0, zero = 1'b0, rmode = 1'b0, sclk = 1'b0;
  logic ser_big, ser_small;
  int   n_vec = 0, n_bad = 0;
  bit   done = 1'b0;

  logic [WB-1:0] w_big;
  logic [WS-1:0] w_small;
  logic          tail_nonzero;

  always #(CLK_PERIOD/2) clk = ~clk;

  msc_serial_counter #(.BYTES(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .zero_i(zero),
    .read_mode_i(rmode), .shift_clk_i(sclk), .ser_o(ser_big)
  );

  msc_serial_counter #(.BYTES(1)) dut_small_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .zero_i(zero),
    .read_mode_i(rmode), .shift_clk_i(sclk), .ser_o(ser_small)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_events(input int unsigned n);
    for (int unsigned i = 0; i < n; i++) begin
      evt = 1'b1; wait_clks(1);
      evt = 1'b0; wait_clks(1);
    end
  endtask

  task automatic do_clear();
    zero = 1'b1; wait_clks(HOLD);
    zero = 1'b0; wait_clks(HOLD);
  endtask

  task automatic enter_read();
    rmode = 1'b1; wait_clks(HOLD);
  endtask

  task automatic leave_read();
    rmode = 1'b0; wait_clks(HOLD);
  endtask

  task automatic shift_once();
    sclk = 1'b1; wait_clks(HOLD);
    sclk = 1'b0; wait_clks(HOLD);
  endtask

  // Read WB bits from both instances; the small one must be 0 after WS bits.
  task automatic read_both();
    w_big = '0; w_small = '0; tail_nonzero = 1'b0;
    for (int i = 0; i < WB; i++) begin
      w_big = {w_big[WB-2:0], ser_big};
      if (i < WS) w_small = {w_small[WS-2:0], ser_small};
      else if (ser_small) tail_nonzero = 1'b1;
      shift_once();
    end
  endtask

  function automatic logic [WB-1:0] exp_big(input int unsigned n);
    return {1'b0, 24'(n)};
  endfunction

  function automatic logic [WS-1:0] exp_small(input int unsigned n);
    return {(n >= 256), 8'(n % 256)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    wait_clks(3);
    // R9: output low during reset
    check("R9 reset ser big", {63'd0, ser_big}, 64'd0);
    check("R9 reset ser small", {63'd0, ser_small}, 64'd0);
    rst_n = 1'b1;
    wait_clks(HOLD);

    // Vector table: clear, count N, read the whole word (R1 R4 R5 R10 R3 R6)
    for (int v = 0; v < NVEC; v++) begin
      do_clear();
      pulse_events(VEC_N[v]);
      enter_read();
      read_both();
      leave_read();
      check($sformatf("R1/R5/R10 big n=%0d", VEC_N[v]), 64'(w_big), 64'(exp_big(VEC_N[v])));
      check($sformatf("R3/R5 small n=%0d", VEC_N[v]), 64'(w_small), 64'(exp_small(VEC_N[v])));
      check($sformatf("R6 small tail n=%0d", VEC_N[v]), {63'd0, tail_nonzero}, 64'd0);
    end

    // R4: wrap flag on ser_o right after entry, before any shift (small wrapped)
    do_clear();
    pulse_events(259);
    enter_read();
    check("R4 first bit is wrap flag", {63'd0, ser_small}, 64'd1);
    check("R4 first bit big is 0", {63'd0, ser_big}, 64'd0);
    leave_read();

    // R3: flag sticky across further events
    pulse_events(4);
    enter_read(); read_both(); leave_read();
    check("R3 sticky flag", 64'(w_small), 64'(exp_small(256 + 7)));
    check("R1 big after more events", 64'(w_big), 64'(exp_big(263)));

    // R6: after the word is drained, extra shifts keep ser_o low
    enter_read(); read_both();
    shift_once(); shift_once();
    check("R6 drained big low", {63'd0, ser_big}, 64'd0);
    leave_read();

    // R7: events and clear ignored in read mode
    enter_read();
    pulse_events(10);
    zero = 1'b1; wait_clks(HOLD); zero = 1'b0; wait_clks(HOLD);
    read_both();
    check("R7 big unchanged", 64'(w_big), 64'(exp_big(263)));
    check("R7 small unchanged", 64'(w_small), 64'(exp_small(263)));
    leave_read();

    // R8: partial read, exit, re-enter restarts from MSB
    enter_read();
    shift_once(); shift_once(); shift_once();
    leave_read();
    enter_read(); read_both(); leave_read();
    check("R8 restart big", 64'(w_big), 64'(exp_big(263)));
    check("R8 restart small", 64'(w_small), 64'(exp_small(263)));

    // R2: count-mode clear zeroes count and wrap flag
    do_clear();
    enter_read(); read_both(); leave_read();
    check("R2 clear big", 64'(w_big), 64'd0);
    check("R2 clear small flag", 64'(w_small), 64'd0);

    // R2: clear held while events arrive; clear wins
    zero = 1'b1; wait_clks(HOLD);
    pulse_events(6);
    zero = 1'b0; wait_clks(HOLD);
    enter_read(); read_both(); leave_read();
    check("R2 clear beats events", 64'(w_big), 64'd0);

    // R9: async reset clears count and flag
    pulse_events(300);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R9 ser low in reset", {63'd0, ser_big}, 64'd0);
    wait_clks(2); rst_n = 1'b1; wait_clks(HOLD);
    enter_read(); read_both(); leave_read();
    check("R9 count zero after reset", 64'(w_big), 64'd0);
    check("R9 flag zero after reset", 64'(w_small), 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule